// File: doc/BRIEF.md
# Register File with Ready-Bit Hazard Interlock

This block is the architectural register file of a simple in-order pipeline, with 32 registers of 32 bits. Each register also carries a ready bit, and the set of ready bits acts as a scoreboard. An instruction in decode presents two source register numbers and, optionally, a destination. The block reports whether both sources are ready. If they are, the instruction issues and its destination is marked pending. If they are not, the block raises a stall request and leaves the scoreboard unchanged.

A single writeback port stores a result and marks its register ready again. Execution always takes one cycle. The block has no forwarding path, so a dependent instruction waits until the producer's result has been written back. Register zero always reads as zero and is always ready. A writeback aimed at a register that is already ready, or at register zero, is an illegal event. It is discarded and reported on an error output.

Top module: `regfile_interlock`

## Requirements
- R1: After reset every register holds zero, every ready bit is set, `stall` and `issue` are low while `dec_valid` is low, and `wb_err` is low.
- R2: `rd_data_a` and `rd_data_b` show, in the same cycle, the stored value of the registers numbered by `dec_src_a` and `dec_src_b` (5-bit register numbers). Register 0 always reads zero.
- R3: While `dec_valid` is high, `issue` is high and `stall` is low exactly when both sources are ready; otherwise `stall` is high and `issue` is low. Both are low while `dec_valid` is low.
- R4: When `issue` is high with `dec_dst_en` high and `dec_dst` nonzero, that register becomes not-ready from the next cycle.
- R5: A stalled instruction, or a cycle with `dec_valid` low, changes no ready bit.
- R6: A writeback (`wb_en` high) to a not-ready nonzero register stores `wb_data` and sets the register ready from the next cycle. A source being written back in the current cycle still stalls in that cycle, because there is no bypass.
- R7: Register 0 is always ready. An issue with destination 0 marks nothing pending, and a writeback to register 0 is discarded.
- R8: A writeback to a register that is already ready, including register 0, leaves both data and ready bit unchanged. It raises `wb_err` for exactly one cycle, in the cycle after the writeback.
- R9: If a legal writeback and an issuing instruction's destination name the same register in the same cycle, the data is stored but the register stays not-ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | An instruction is present in decode |
| dec_src_a | input | 5 | First source register number |
| dec_src_b | input | 5 | Second source register number |
| dec_dst_en | input | 1 | The instruction writes a destination |
| dec_dst | input | 5 | Destination register number |
| rd_data_a | output | 32 | Value of the first source register |
| rd_data_b | output | 32 | Value of the second source register |
| stall | output | 1 | Decode must hold: a source is pending |
| issue | output | 1 | The decode instruction proceeds this cycle |
| wb_en | input | 1 | Writeback valid |
| wb_idx | input | 5 | Writeback register number |
| wb_data | input | 32 | Writeback value |
| wb_err | output | 1 | One-cycle pulse after an illegal writeback |

## Verification
The bench targets the cycle in which a result is written back while a consumer already waits in decode. A design that bypassed the ready bit would release the consumer one cycle early. It also drives a writeback and a new issue to the same register in the same cycle; a design that let the writeback win would clear the hazard and let a stale read through. Instructions are held stalled with a destination to confirm they do not mark that destination pending; a design that cleared the bit at stall time would later deadlock on its own output. Writebacks are also sent to register zero and to registers that are already ready. A design that accepted these would corrupt the data seen afterwards and leave `wb_err` low.

// File: rtl/rfi_pkg.sv
package rfi_pkg;
    parameter int unsigned RFI_NUM_REGS = 32;
    parameter int unsigned RFI_DATA_W   = 32;

    typedef enum logic [1:0] {
        WB_IDLE   = 2'd0,
        WB_COMMIT = 2'd1,
        WB_REJECT = 2'd2
    } wb_kind_e;
endpackage

// File: rtl/rfi_wb_classify.sv
module rfi_wb_classify
    import rfi_pkg::*;
#(
    parameter int unsigned NUM_REGS = RFI_NUM_REGS,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                wb_en,
    input  logic [IDX_W-1:0]    wb_idx,
    input  logic [NUM_REGS-1:0] ready_vec,
    output wb_kind_e            kind
);
    // A result may only land on a register that is waiting for it.
    always_comb begin
        if (!wb_en) begin
            kind = WB_IDLE;
        end else if (wb_idx == '0 || ready_vec[wb_idx]) begin
            kind = WB_REJECT;
        end else begin
            kind = WB_COMMIT;
        end
    end
endmodule

// File: rtl/rfi_hazard.sv
module rfi_hazard #(
    parameter int unsigned NUM_REGS = rfi_pkg::RFI_NUM_REGS,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                dec_valid,
    input  logic [IDX_W-1:0]    src_a,
    input  logic [IDX_W-1:0]    src_b,
    input  logic                dst_en,
    input  logic [IDX_W-1:0]    dst,
    input  logic [NUM_REGS-1:0] ready_vec,
    output logic                stall,
    output logic                issue,
    output logic [NUM_REGS-1:0] clear_mask
);
    logic srcs_ready;

    always_comb begin
        srcs_ready = ready_vec[src_a] && ready_vec[src_b];
        issue      = dec_valid && srcs_ready;
        stall      = dec_valid && !srcs_ready;
    end

    // One pending-mark lane per register; lane 0 never fires.
    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_clear
            if (g == 0) begin : g_zero
                assign clear_mask[g] = 1'b0;
            end else begin : g_reg
                assign clear_mask[g] = issue && dst_en && (dst == IDX_W'(g));
            end
        end
    endgenerate
endmodule

// File: rtl/rfi_store.sv
module rfi_store
    import rfi_pkg::*;
#(
    parameter int unsigned NUM_REGS = RFI_NUM_REGS,
    parameter int unsigned DATA_W   = RFI_DATA_W,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  wb_kind_e            wb_kind,
    input  logic [IDX_W-1:0]    wb_idx,
    input  logic [DATA_W-1:0]   wb_data,
    input  logic [NUM_REGS-1:0] clear_mask,
    input  logic [IDX_W-1:0]    rd_idx_a,
    input  logic [IDX_W-1:0]    rd_idx_b,
    output logic [NUM_REGS-1:0] ready_vec,
    output logic [DATA_W-1:0]   rd_data_a,
    output logic [DATA_W-1:0]   rd_data_b,
    output logic                err
);
    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] data;
        logic [NUM_REGS-1:0]             ready;
        logic                            err;
    } state_t;

    state_t s_d;
    state_t s_q;

    always_comb begin
        s_d     = s_q;
        s_d.err = (wb_kind == WB_REJECT);
        if (wb_kind == WB_COMMIT) begin
            s_d.data[wb_idx]  = wb_data;
            s_d.ready[wb_idx] = 1'b1;
        end
        // The newer instruction's pending mark overrides the writeback.
        s_d.ready   = s_d.ready & ~clear_mask;
        s_d.ready[0] = 1'b1;
        s_d.data[0]  = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.data  <= '0;
            s_q.ready <= '1;
            s_q.err   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ready_vec = s_q.ready;
    assign rd_data_a = s_q.data[rd_idx_a];
    assign rd_data_b = s_q.data[rd_idx_b];
    assign err       = s_q.err;
endmodule

// File: rtl/regfile_interlock.sv
module regfile_interlock
    import rfi_pkg::*;
#(
    parameter int unsigned NUM_REGS = RFI_NUM_REGS,
    parameter int unsigned DATA_W   = RFI_DATA_W,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_valid,
    input  logic [IDX_W-1:0]  dec_src_a,
    input  logic [IDX_W-1:0]  dec_src_b,
    input  logic              dec_dst_en,
    input  logic [IDX_W-1:0]  dec_dst,
    output logic [DATA_W-1:0] rd_data_a,
    output logic [DATA_W-1:0] rd_data_b,
    output logic              stall,
    output logic              issue,
    input  logic              wb_en,
    input  logic [IDX_W-1:0]  wb_idx,
    input  logic [DATA_W-1:0] wb_data,
    output logic              wb_err
);
    logic [NUM_REGS-1:0] ready_vec;
    logic [NUM_REGS-1:0] clear_mask;
    wb_kind_e            wb_kind;

    rfi_wb_classify #(.NUM_REGS(NUM_REGS)) u_classify (
        .wb_en     (wb_en),
        .wb_idx    (wb_idx),
        .ready_vec (ready_vec),
        .kind      (wb_kind)
    );

    rfi_hazard #(.NUM_REGS(NUM_REGS)) u_hazard (
        .dec_valid  (dec_valid),
        .src_a      (dec_src_a),
        .src_b      (dec_src_b),
        .dst_en     (dec_dst_en),
        .dst        (dec_dst),
        .ready_vec  (ready_vec),
        .stall      (stall),
        .issue      (issue),
        .clear_mask (clear_mask)
    );

    rfi_store #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wb_kind    (wb_kind),
        .wb_idx     (wb_idx),
        .wb_data    (wb_data),
        .clear_mask (clear_mask),
        .rd_idx_a   (dec_src_a),
        .rd_idx_b   (dec_src_b),
        .ready_vec  (ready_vec),
        .rd_data_a  (rd_data_a),
        .rd_data_b  (rd_data_b),
        .err        (wb_err)
    );
endmodule

// File: rtl/regfile_interlock_chk.sv
module regfile_interlock_chk #(
    parameter int unsigned NUM_REGS = rfi_pkg::RFI_NUM_REGS,
    parameter int unsigned DATA_W   = rfi_pkg::RFI_DATA_W,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dec_valid,
    input logic [IDX_W-1:0]  dec_src_a,
    input logic [IDX_W-1:0]  dec_src_b,
    input logic              dec_dst_en,
    input logic [IDX_W-1:0]  dec_dst,
    input logic [DATA_W-1:0] rd_data_a,
    input logic [DATA_W-1:0] rd_data_b,
    input logic              stall,
    input logic              issue,
    input logic              wb_en,
    input logic [IDX_W-1:0]  wb_idx,
    input logic [DATA_W-1:0] wb_data,
    input logic              wb_err
);
    // R3
    stall_issue_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(stall && issue));

    // R3
    handshake_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall || issue) |-> dec_valid);

    // R2
    zero_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_src_b == '0) |-> (rd_data_b == '0));

    // R4
    dst_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && dec_dst_en && dec_dst != '0)
        |=> ((dec_valid && dec_src_a == $past(dec_dst)) |-> stall));

    // R6
    wb_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && wb_idx != '0)
        |=> ((!wb_err && dec_src_a == $past(wb_idx)) |-> (rd_data_a == $past(wb_data))));

    // R8
    err_follows_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_err |-> $past(wb_en));
endmodule

bind regfile_interlock regfile_interlock_chk #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W)
) u_chk (.*);

// File: tb/regfile_interlock_test.sv
module regfile_interlock_test;
    localparam int NR = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dec_valid = 1'b0;
    logic [4:0]  dec_src_a = '0;
    logic [4:0]  dec_src_b = '0;
    logic        dec_dst_en = 1'b0;
    logic [4:0]  dec_dst = '0;
    logic [31:0] rd_data_a;
    logic [31:0] rd_data_b;
    logic        stall;
    logic        issue;
    logic        wb_en = 1'b0;
    logic [4:0]  wb_idx = '0;
    logic [31:0] wb_data = '0;
    logic        wb_err;

    regfile_interlock uut (.*);

    always #5 clk = ~clk;

    typedef struct packed {
        logic        stl;
        logic        iss;
        logic [31:0] a;
        logic [31:0] b;
        logic        err;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    event  sample_ev;

    int n_checks = 0;
    int n_errs   = 0;
    bit done     = 0;

    logic [31:0] m_data [NR];
    logic        m_rdy  [NR];
    logic        m_err;

    function automatic void chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endfunction

    function automatic logic m_ready(logic [4:0] r);
        return (r == 5'd0) || m_rdy[r];
    endfunction

    // Monitor: pops each expectation as the design presents its outputs.
    initial begin
        forever begin
            @(sample_ev);
            while (exp_q.size() > 0) begin
                exp_t  e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, "stall", {31'b0, stall}, {31'b0, e.stl});
                chk(t, "issue", {31'b0, issue}, {31'b0, e.iss});
                chk(t, "rd_data_a", rd_data_a, e.a);
                chk(t, "rd_data_b", rd_data_b, e.b);
                chk(t, "wb_err", {31'b0, wb_err}, {31'b0, e.err});
            end
        end
    end

    // Driver: applies one cycle of stimulus, predicts, then advances the model.
    task automatic step(string tag, logic v, logic [4:0] sa, logic [4:0] sb,
                        logic de, logic [4:0] d, logic we, logic [4:0] wi, logic [31:0] wd);
        exp_t e;
        logic is_iss;
        logic bad_wb;
        @(negedge clk);
        dec_valid = v; dec_src_a = sa; dec_src_b = sb; dec_dst_en = de; dec_dst = d;
        wb_en = we; wb_idx = wi; wb_data = wd;
        #1;
        is_iss = v && m_ready(sa) && m_ready(sb);
        e.stl  = v && !is_iss;
        e.iss  = is_iss;
        e.a    = (sa == 5'd0) ? 32'd0 : m_data[sa];
        e.b    = (sb == 5'd0) ? 32'd0 : m_data[sb];
        e.err  = m_err;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        -> sample_ev;
        @(posedge clk);
        bad_wb = we && m_ready(wi);
        m_err  = bad_wb;
        if (we && !bad_wb) begin
            m_data[wi] = wd;
            m_rdy[wi]  = 1'b1;
        end
        if (is_iss && de && d != 5'd0) m_rdy[d] = 1'b0;
    endtask

    task automatic probe(string tag, logic [4:0] sa, logic [4:0] sb);
        step(tag, 1'b1, sa, sb, 1'b0, 5'd0, 1'b0, 5'd0, 32'd0);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_errs++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NR; i++) begin
            m_data[i] = '0;
            m_rdy[i]  = 1'b1;
        end
        m_err = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, idle decode
        step("R1", 1'b0, 5'd3, 5'd31, 1'b1, 5'd4, 1'b0, 5'd0, 32'd0);
        probe("R1", 5'd1, 5'd2);

        // R7 R8: writeback to register zero is rejected and flagged
        step("R7", 1'b0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b1, 5'd0, 32'hDEAD_BEEF);
        probe("R8", 5'd0, 5'd0);
        // R7: issue with destination 0 leaves it ready
        step("R7", 1'b1, 5'd0, 5'd0, 1'b1, 5'd0, 1'b0, 5'd0, 32'd0);
        probe("R7", 5'd0, 5'd0);

        // R4: issue writes register 5 pending
        step("R4", 1'b1, 5'd1, 5'd2, 1'b1, 5'd5, 1'b0, 5'd0, 32'd0);
        probe("R4", 5'd5, 5'd1);
        probe("R3", 5'd2, 5'd5);
        // R5: stalled instruction naming register 6 must not mark it
        step("R5", 1'b1, 5'd5, 5'd0, 1'b1, 5'd6, 1'b0, 5'd0, 32'd0);
        step("R5", 1'b1, 5'd0, 5'd5, 1'b1, 5'd6, 1'b0, 5'd0, 32'd0);
        probe("R5", 5'd6, 5'd6);
        // R5 R3: dec_valid low with a destination marks nothing
        step("R5", 1'b0, 5'd0, 5'd0, 1'b1, 5'd8, 1'b0, 5'd0, 32'd0);
        probe("R5", 5'd8, 5'd0);

        // R6: writeback in the same cycle as a waiting consumer: no bypass
        step("R6", 1'b1, 5'd5, 5'd0, 1'b1, 5'd9, 1'b1, 5'd5, 32'h1234_5678);
        step("R6", 1'b1, 5'd5, 5'd0, 1'b1, 5'd9, 1'b0, 5'd0, 32'd0);
        probe("R2", 5'd9, 5'd5);

        // R8: second writeback to now-ready register 5 rejected
        step("R8", 1'b0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b1, 5'd5, 32'hFFFF_0000);
        probe("R8", 5'd5, 5'd0);
        probe("R8", 5'd5, 5'd0);

        // R9: writeback and re-issue of register 9 in one cycle
        step("R9", 1'b1, 5'd0, 5'd0, 1'b1, 5'd9, 1'b1, 5'd9, 32'hCAFE_F00D);
        probe("R9", 5'd9, 5'd0);
        step("R9", 1'b0, 5'd0, 5'd0, 1'b0, 5'd0, 1'b1, 5'd9, 32'h0BAD_CAFE);
        probe("R9", 5'd9, 5'd9);

        // R2 R3 R6 R8: mixed traffic
        for (int n = 0; n < 400; n++) begin
            logic [4:0] wi;
            logic       we;
            wi = 5'($urandom_range(0, 31));
            we = ($urandom_range(0, 3) != 0);
            for (int k = 0; k < 8; k++) begin
                logic [4:0] c;
                c = 5'($urandom_range(1, 31));
                if (!m_rdy[c] && $urandom_range(0, 9) != 0) wi = c;
            end
            step("R3", 1'($urandom_range(0, 1)), 5'($urandom_range(0, 31)),
                 5'($urandom_range(0, 31)), 1'($urandom_range(0, 1)),
                 5'($urandom_range(0, 31)), we, wi, $urandom);
        end
        probe("R2", 5'd0, 5'd0);

        @(negedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    end
endmodule